// File: doc/BRIEF.md
# Debug Trace Window and Breakpoint Sequencer

This block sits in an on-chip debug unit between the trigger logic and the trace storage. A register write arms it. A trigger then decides how the trace window behaves and whether the CPU gets a breakpoint request. The trigger can be a software trigger bit in that write, or a final-state pulse from one of the hardware comparator sequencers. Trace capture may run before the trigger and stop there (end alignment), or start at the trigger and run until the trace storage reports full (begin alignment). It may also be cut short at the trigger by a break-immediate option.

The configuration bits are latched at the arm write, so they stay fixed for the whole session. When a session ends, the block gives a one-cycle disarm pulse. Any breakpoint request for that session is a one-cycle pulse in the same cycle, and the block drops its armed flag. A new arm write is needed before the next session. No data flows through the block: every pin is a plain control or status level or pulse, and there is no back-pressure.

Top module: `dbg_seq`

## Requirements
- R1: If armed with trace source on, end alignment, break-immediate off and breakpoint off, then trace_en is high while waiting. A trigger ends the session one cycle later with disarm_pulse high and bkpt_req low.
- R2: The same setup with breakpoint enabled ends one cycle after the trigger with bkpt_req and disarm_pulse both high.
- R3: If armed with trace source on, begin alignment, break-immediate off and breakpoint off, then trace_en is low while waiting. It is high from the cycle after the trigger. The session ends one cycle after buf_full is seen, with no breakpoint.
- R4: With begin alignment and breakpoint enabled, the trigger itself raises no request. bkpt_req pulses, together with disarm_pulse, one cycle after buf_full is seen during capture.
- R5: With break-immediate set, alignment is ignored. A trigger ends the session one cycle later, and bkpt_req equals the breakpoint-enable bit.
- R6: With trace source off, trace_en stays low. A trigger ends the session one cycle later, and bkpt_req equals the breakpoint-enable bit.
- R7: A write with cfg_we, cfg_arm and cfg_trig all high arms the block and triggers it at once. A write with cfg_trig high while the block waits is a trigger, just as a pulse on any hw_final bit is.
- R8: Once begin-aligned capture runs, further software triggers and hw_final pulses have no effect: armed and trace_en stay high and no pulse appears.
- R9: While not armed, triggers and buf_full have no effect: no pulse appears and armed stays low.
- R10: Configuration inputs that change while armed have no effect on the running session.
- R11: armed rises the cycle after an arm write and falls together with disarm_pulse. bkpt_req never appears without disarm_pulse, and neither output is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Control register write strobe |
| cfg_arm | input | 1 | Arm bit of the write |
| cfg_trig | input | 1 | Software trigger bit of the write |
| cfg_trace_src | input | 1 | A tracing session is selected |
| cfg_brk_now | input | 1 | Break-immediate option |
| cfg_align_begin | input | 1 | 1 = begin alignment, 0 = end alignment |
| cfg_bkpt_en | input | 1 | Breakpoint enable |
| hw_final | input | N_HW_TRIG | Final-state pulses from comparator sequencers |
| buf_full | input | 1 | Trace storage full flag |
| trace_en | output | 1 | Trace capture enable |
| bkpt_req | output | 1 | Breakpoint request pulse to the CPU |
| disarm_pulse | output | 1 | One-cycle end-of-session pulse |
| armed | output | 1 | Session in progress |

## Verification
A wrong session state shows up at the ports within one cycle. If the block is stuck waiting, it never gives disarm_pulse and armed stays high. If it falsely enters capture, trace_en goes high when it should not. If it misses the deferral, bkpt_req fires in the cycle after the trigger instead of after buf_full. A wrong latched configuration only shows up at the end of the session, as a bkpt_req value that differs from the one stored at the arm write. So every session is closed and its end pulse is compared against the expected breakpoint value.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CAPT = 2'd2
  } sess_state_e;

  typedef struct packed {
    logic trace_src;
    logic brk_now;
    logic align_begin;
    logic bkpt_en;
  } sess_cfg_t;
endpackage

// File: rtl/dbg_cfg_latch.sv
module dbg_cfg_latch
  import dbg_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  sess_cfg_t cfg_in,
  output sess_cfg_t cfg_eff,
  output logic      fill_pre_q,
  output logic      bkpt_en_q
);
  sess_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (load) cfg_q <= cfg_in;
  end

  // the arm write itself may trigger, so its own bits apply at once
  assign cfg_eff    = load ? cfg_in : cfg_q;
  assign fill_pre_q = cfg_q.trace_src & ~cfg_q.align_begin;
  assign bkpt_en_q  = cfg_q.bkpt_en;
endmodule

// File: rtl/dbg_trig_detect.sv
module dbg_trig_detect #(
  parameter int N_HW_TRIG = 2
) (
  input  logic                 sw_trig,
  input  logic [N_HW_TRIG-1:0] hw_final,
  input  logic                 window,
  output logic                 trig_evt
);
  logic [N_HW_TRIG:0] any_chain;

  assign any_chain[0] = sw_trig;
  for (genvar g = 0; g < N_HW_TRIG; g++) begin : g_or
    assign any_chain[g+1] = any_chain[g] | hw_final[g];
  end

  assign trig_evt = window & any_chain[N_HW_TRIG];
endmodule

// File: rtl/dbg_action_decode.sv
module dbg_action_decode (
  input  logic trace_src,
  input  logic brk_now,
  input  logic align_begin,
  output logic defer
);
  // capture continues past the trigger only for a begin-aligned trace
  // that break-immediate does not cut short
  assign defer = trace_src & ~brk_now & align_begin;
endmodule

// File: rtl/dbg_session_fsm.sv
module dbg_session_fsm
  import dbg_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_now,
  input  logic trig_evt,
  input  logic defer,
  input  logic bkpt_en_eff,
  input  logic bkpt_en_q,
  input  logic fill_pre_q,
  input  logic buf_full,
  output logic waiting,
  output logic armed,
  output logic trace_en,
  output logic bkpt_req,
  output logic disarm_pulse
);
  sess_state_e state, state_nx;
  logic end_nx, bkpt_nx;

  always_comb begin
    state_nx = state;
    end_nx   = 1'b0;
    bkpt_nx  = 1'b0;
    unique case (state)
      ST_IDLE, ST_WAIT: begin
        if (state == ST_WAIT || arm_now) begin
          if (trig_evt) begin
            if (defer) state_nx = ST_CAPT;
            else begin
              state_nx = ST_IDLE;
              end_nx   = 1'b1;
              bkpt_nx  = bkpt_en_eff;
            end
          end else state_nx = ST_WAIT;
        end
      end
      ST_CAPT: begin
        if (buf_full) begin
          state_nx = ST_IDLE;
          end_nx   = 1'b1;
          bkpt_nx  = bkpt_en_q;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      bkpt_req     <= 1'b0;
      disarm_pulse <= 1'b0;
    end else begin
      state        <= state_nx;
      bkpt_req     <= bkpt_nx;
      disarm_pulse <= end_nx;
    end
  end

  assign waiting  = (state == ST_WAIT);
  assign armed    = (state != ST_IDLE);
  assign trace_en = (waiting & fill_pre_q) | (state == ST_CAPT);

  // R11
  bkpt_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_req |-> disarm_pulse);
  // R11
  end_drops_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_pulse |-> !armed);
  // R6
  trace_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trace_en |-> armed);
  // R4
  capt_no_early_bkpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAPT && !buf_full) |=> !bkpt_req);
  // R8
  capt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAPT && !buf_full) |=> (state == ST_CAPT));
  // R10
  latched_bk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !bkpt_en_q) |=> !bkpt_req);
endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
  import dbg_seq_pkg::*;
#(
  parameter int N_HW_TRIG = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_arm,
  input  logic                 cfg_trig,
  input  logic                 cfg_trace_src,
  input  logic                 cfg_brk_now,
  input  logic                 cfg_align_begin,
  input  logic                 cfg_bkpt_en,
  input  logic [N_HW_TRIG-1:0] hw_final,
  input  logic                 buf_full,
  output logic                 trace_en,
  output logic                 bkpt_req,
  output logic                 disarm_pulse,
  output logic                 armed
);
  sess_cfg_t cfg_in, cfg_eff;
  logic arm_now, waiting, trig_evt, defer, fill_pre_q, bkpt_en_q;

  assign cfg_in  = '{trace_src: cfg_trace_src, brk_now: cfg_brk_now,
                     align_begin: cfg_align_begin, bkpt_en: cfg_bkpt_en};
  assign arm_now = cfg_we & cfg_arm & ~armed;

  dbg_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .load(arm_now), .cfg_in(cfg_in),
    .cfg_eff(cfg_eff), .fill_pre_q(fill_pre_q), .bkpt_en_q(bkpt_en_q)
  );

  dbg_trig_detect #(.N_HW_TRIG(N_HW_TRIG)) u_trig (
    .sw_trig(cfg_we & cfg_trig), .hw_final(hw_final),
    .window(waiting | arm_now), .trig_evt(trig_evt)
  );

  dbg_action_decode u_dec (
    .trace_src(cfg_eff.trace_src), .brk_now(cfg_eff.brk_now),
    .align_begin(cfg_eff.align_begin), .defer(defer)
  );

  dbg_session_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .arm_now(arm_now), .trig_evt(trig_evt),
    .defer(defer), .bkpt_en_eff(cfg_eff.bkpt_en), .bkpt_en_q(bkpt_en_q),
    .fill_pre_q(fill_pre_q), .buf_full(buf_full), .waiting(waiting),
    .armed(armed), .trace_en(trace_en), .bkpt_req(bkpt_req),
    .disarm_pulse(disarm_pulse)
  );

  // R7
  arm_write_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_now && !(cfg_trig || |hw_final)) |=> armed);
endmodule

// File: tb/dbg_seq_bench.sv
module dbg_seq_bench;
  localparam int NH = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_arm = 0, cfg_trig = 0;
  logic cfg_trace_src = 0, cfg_brk_now = 0, cfg_align_begin = 0, cfg_bkpt_en = 0;
  logic [NH-1:0] hw_final = '0;
  logic buf_full = 0;
  logic trace_en, bkpt_req, disarm_pulse, armed;

  int checks = 0, fails = 0;
  bit done = 0;
  logic exp_q[$];
  logic prev_bk = 0, prev_dis = 0;

  always #2 clk = ~clk;

  dbg_seq #(.N_HW_TRIG(NH)) u_dbg_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_arm(cfg_arm),
    .cfg_trig(cfg_trig), .cfg_trace_src(cfg_trace_src),
    .cfg_brk_now(cfg_brk_now), .cfg_align_begin(cfg_align_begin),
    .cfg_bkpt_en(cfg_bkpt_en), .hw_final(hw_final), .buf_full(buf_full),
    .trace_en(trace_en), .bkpt_req(bkpt_req), .disarm_pulse(disarm_pulse),
    .armed(armed)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // monitor: every end-of-session pulse pops one scoreboard entry
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (disarm_pulse) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R9: got disarm_pulse=1 expected 0 (no session end due)");
        end else begin
          logic e;
          e = exp_q.pop_front();
          if (bkpt_req !== e) begin
            fails++;
            $display("FAIL R1/R2/R4/R5/R6: got bkpt_req=%b expected %b", bkpt_req, e);
          end
        end
      end
      if (bkpt_req && !disarm_pulse) begin
        checks++; fails++;
        $display("FAIL R11: got bkpt_req=1 disarm_pulse=0 expected both high");
      end
      if ((bkpt_req && prev_bk) || (disarm_pulse && prev_dis)) begin
        checks++; fails++;
        $display("FAIL R11: got two-cycle pulse expected single cycle");
      end
      prev_bk  = bkpt_req;
      prev_dis = disarm_pulse;
    end
  end

  task automatic arm(input logic trig, src, brk, beg, bk, input bit ends, input logic exp_bk);
    @(negedge clk);
    cfg_we = 1; cfg_arm = 1; cfg_trig = trig;
    cfg_trace_src = src; cfg_brk_now = brk; cfg_align_begin = beg; cfg_bkpt_en = bk;
    if (ends) exp_q.push_back(exp_bk);
    @(negedge clk);
    cfg_we = 0; cfg_arm = 0; cfg_trig = 0;
  endtask

  task automatic sw_trig(input bit ends, input logic exp_bk);
    @(negedge clk);
    cfg_we = 1; cfg_trig = 1;
    if (ends) exp_q.push_back(exp_bk);
    @(negedge clk);
    cfg_we = 0; cfg_trig = 0;
  endtask

  task automatic hw_pulse(input int idx, input bit ends, input logic exp_bk);
    @(negedge clk);
    hw_final[idx] = 1'b1;
    if (ends) exp_q.push_back(exp_bk);
    @(negedge clk);
    hw_final = '0;
  endtask

  task automatic full_pulse(input bit ends, input logic exp_bk);
    @(negedge clk);
    buf_full = 1;
    if (ends) exp_q.push_back(exp_bk);
    @(negedge clk);
    buf_full = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset armed", armed, 0);
    chk("R11 reset trace_en", trace_en, 0);
    chk("R11 reset bkpt_req", bkpt_req, 0);
    rst_n = 1;

    // R1 end aligned, no breakpoint
    arm(0, 1, 0, 0, 0, 0, 0);
    chk("R11 armed after arm", armed, 1);
    chk("R1 trace before trigger", trace_en, 1);
    hw_pulse(0, 1, 0);
    chk("R11 armed cleared", armed, 0);
    chk("R1 trace off after end", trace_en, 0);

    // R2 end aligned with breakpoint
    arm(0, 1, 0, 0, 1, 0, 0);
    hw_pulse(1, 1, 1);
    chk("R2 armed cleared", armed, 0);

    // R3 begin aligned, no breakpoint
    arm(0, 1, 0, 1, 0, 0, 0);
    chk("R3 trace off while waiting", trace_en, 0);
    hw_pulse(0, 0, 0);
    chk("R3 trace on after trigger", trace_en, 1);
    chk("R3 still armed", armed, 1);
    full_pulse(1, 0);
    chk("R3 armed cleared on full", armed, 0);

    // R4 + R8 begin aligned with breakpoint, late triggers ignored
    arm(0, 1, 0, 1, 1, 0, 0);
    sw_trig(0, 0);
    chk("R4 trace on after sw trigger", trace_en, 1);
    sw_trig(0, 0);
    hw_pulse(1, 0, 0);
    chk("R8 still armed after late triggers", armed, 1);
    chk("R8 trace still on", trace_en, 1);
    full_pulse(1, 1);
    chk("R4 armed cleared", armed, 0);

    // R5 break-immediate overrides alignment
    arm(0, 1, 1, 1, 1, 0, 0);
    hw_pulse(0, 1, 1);
    chk("R5 terminated at trigger", armed, 0);
    arm(0, 1, 1, 0, 0, 0, 0);
    hw_pulse(1, 1, 0);
    chk("R5 terminated, no bkpt", armed, 0);

    // R6 no tracing session selected
    arm(0, 0, 0, 1, 1, 0, 0);
    chk("R6 trace stays off", trace_en, 0);
    hw_pulse(0, 1, 1);
    chk("R6 ended at trigger", armed, 0);

    // R7 arm and trigger in the same write, then sw trigger while waiting
    arm(1, 1, 0, 0, 1, 1, 1);
    chk("R7 armed cleared after combined write", armed, 0);
    arm(0, 1, 0, 0, 0, 0, 0);
    sw_trig(1, 0);
    chk("R7 sw trigger ended session", armed, 0);

    // R9 triggers while idle do nothing
    hw_pulse(0, 0, 0);
    sw_trig(0, 0);
    full_pulse(0, 0);
    chk("R9 still not armed", armed, 0);
    chk("R9 trace off", trace_en, 0);

    // R10 configuration change while armed ignored
    arm(0, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    cfg_bkpt_en = 1; cfg_align_begin = 1; cfg_trace_src = 0;
    @(negedge clk);
    chk("R10 trace follows latched config", trace_en, 1);
    hw_pulse(0, 1, 0);
    chk("R10 session ended", armed, 0);

    repeat (3) @(negedge clk);
    chk("R11 all expected ends seen", exp_q.size() == 0, 1);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule